// File: doc/BRIEF.md
# Grouped Programmable-Priority Interrupt Controller

This block gathers internal and external interrupt request lines and holds each one in a pending bit. From the pending sources that software has enabled, it picks one winner and reports it as a 7-bit vector together with a single interrupt request to the processor. The sources are arranged in groups of eight lanes. The last `NUM_MIXED` groups are mixed groups: four lanes come from internal lines and four from external pins.

Priority is resolved in two levels. Inside a group, eight slot fields name the lanes from highest to lowest. Software may rewrite these fields at any time, so it can rotate priority among the lanes. Across groups, each group has a placement bit. A grouped (clustered) group sits in the top half of a global position table. A spread group takes every other position in the lower half, interleaved with one partner group. The lowest position wins. One source can also be named as an override, which beats every table position.

A single write port carries every change: enables, placement, override and slot orders, plus the acknowledge, which clears pending bits. The pending vector is always visible on an output port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source number n = 8*group + lane owns pending bit n (`pend_o[n]`). The bit is set on the clock edge at which its line is high, whether or not the source is enabled.
- R2: Writing to address 0 clears every pending bit whose data bit is 1, and leaves the other bits alone. If the line of a source is still high on that edge, its bit stays set.
- R3: `vec_out` carries the winner's source number plus 1, and `irq_out` is high. Both are registered: they reflect the pending, enable, placement, order and override state one clock after that state changes.
- R4: When no pending source is enabled, or none can be reported, `vec_out` is 0 and `irq_out` is low.
- R5: Address 1 holds one enable bit per source, where 1 means enabled. A disabled source never wins, but its pending bit still sets and reads back.
- R6: Address 4+g holds the order of group g. Slot s sits in data bits [3s+2:3s] and names a lane. Slot 0 has the highest priority. A rewrite takes effect on the next evaluation, which allows rotation.
- R7: If a lane is named in several slots, the lowest of those slots sets its rank. A lane named by no slot is never reported, even though it stays pending.
- R8: Address 2 bit g selects the placement of group g: 0 is grouped, 1 is spread. A grouped group's slot s sits at position 8g+s. A spread group's slot s sits at position 32 + 16*(g/2) + (g mod 2) + 2s. The lowest position wins.
- R9: Address 3 sets the override: bits [4:0] name a source and bit 8 enables the override. When that source is pending and enabled, it wins over every table position. When it is not, selection proceeds as usual.
- R10: Groups 0–1 take `int_irq[8g+lane]`. In mixed group g ≥ 2, lanes 0–3 take `int_irq[16+4(g-2)+lane]` and lanes 4–7 take `ext_irq[4(g-2)+lane-4]`.
- R11: After reset, all pending bits and enables are 0, every group is grouped, the override is off, and every group's order is the identity (slot s names lane s).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_irq | input | 24 | Internal request lines, active high |
| ext_irq | input | 8 | External request lines after pin conditioning, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pend_o | output | 32 | Pending bits, indexed by source number |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 7 | Winner's source number plus 1, or 0 |

## Verification
The properties assume two things about the inputs. First, request lines and register writes are stable across each rising edge. Second, reset is asserted from time zero, so every `$past` term starts from the reset state. The properties make no assumption that slot fields form a permutation, so duplicate or missing lanes are legal stimulus. The bench changes every input only on the falling clock edge. It holds reset low for its first cycles, and it includes random slot words that contain repeated lanes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int VEC_W       = 7;
   localparam int HP_EN_BIT   = 8;
   localparam int ADDR_PEND   = 0;
   localparam int ADDR_MASK   = 1;
   localparam int ADDR_PLACE  = 2;
   localparam int ADDR_TOP    = 3;
   localparam int ADDR_ORDER0 = 4;

   typedef enum logic {
      PLACE_GROUPED = 1'b0,
      PLACE_SPREAD  = 1'b1
   } place_e;
endpackage

// File: rtl/irqc_src_map.sv
// Gathers internal and external lines into one source vector, 8*group + lane.
module irqc_src_map #(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_SIZE = 8,
   parameter int NUM_MIXED  = 2,
   localparam int NSRC      = NUM_GROUPS * GROUP_SIZE,
   localparam int HALF      = GROUP_SIZE / 2,
   localparam int NUM_EXT   = NUM_MIXED * HALF,
   localparam int NUM_INT   = NSRC - NUM_EXT,
   localparam int NUM_PLAIN = NUM_GROUPS - NUM_MIXED
) (
   input  logic [NUM_INT-1:0] int_irq,
   input  logic [NUM_EXT-1:0] ext_irq,
   output logic [NSRC-1:0]    src
);
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      for (genvar l = 0; l < GROUP_SIZE; l++) begin : g_lane
         if (g < NUM_PLAIN) begin : g_plain
            assign src[g*GROUP_SIZE + l] = int_irq[g*GROUP_SIZE + l];
         end else if (l < HALF) begin : g_mix_int
            assign src[g*GROUP_SIZE + l] = int_irq[NUM_PLAIN*GROUP_SIZE + (g-NUM_PLAIN)*HALF + l];
         end else begin : g_mix_ext
            assign src[g*GROUP_SIZE + l] = ext_irq[(g-NUM_PLAIN)*HALF + l - HALF];
         end
      end
   end
endmodule

// File: rtl/irqc_pend_bank.sv
// Pending latch with write-one-to-clear acknowledge, plus the enable register.
module irqc_pend_bank import irqc_pkg::*; #(
   parameter int NSRC   = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NSRC-1:0]   pend_q,
   output logic [NSRC-1:0]   mask_q
);
   logic [NSRC-1:0] ack;

   assign ack = (wr_en && wr_addr == ADDR_W'(ADDR_PEND)) ? wr_data[NSRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         // a line still high outranks the acknowledge in the same cycle
         pend_q <= (pend_q & ~ack) | src;
         if (wr_en && wr_addr == ADDR_W'(ADDR_MASK))
            mask_q <= wr_data[NSRC-1:0];
      end
   end
endmodule

// File: rtl/irqc_group_rank.sv
// Finds the lowest slot whose named lane is requesting.
module irqc_group_rank #(
   parameter int GROUP_SIZE = 8,
   localparam int LANE_W    = $clog2(GROUP_SIZE)
) (
   input  logic [GROUP_SIZE-1:0]        req,
   input  logic [GROUP_SIZE*LANE_W-1:0] order,
   output logic                         hit,
   output logic [LANE_W-1:0]            slot,
   output logic [LANE_W-1:0]            lane
);
   always_comb begin
      hit  = 1'b0;
      slot = '0;
      lane = '0;
      for (int s = GROUP_SIZE - 1; s >= 0; s--) begin
         if (req[order[s*LANE_W +: LANE_W]]) begin
            hit  = 1'b1;
            slot = LANE_W'(s);
            lane = order[s*LANE_W +: LANE_W];
         end
      end
   end
endmodule

// File: rtl/irqc_table_arb.sv
// Places each group's best slot in the global table and keeps the lowest position.
module irqc_table_arb import irqc_pkg::*; #(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_SIZE = 8,
   localparam int LANE_W    = $clog2(GROUP_SIZE),
   localparam int NSRC      = NUM_GROUPS * GROUP_SIZE,
   localparam int SRC_W     = $clog2(NSRC),
   localparam int POS_W     = $clog2(3 * NSRC)
) (
   input  logic [NUM_GROUPS-1:0]        hit,
   input  logic [NUM_GROUPS*LANE_W-1:0] slot,
   input  logic [NUM_GROUPS*LANE_W-1:0] lane,
   input  logic [NUM_GROUPS-1:0]        place,
   output logic                         win_v,
   output logic [SRC_W-1:0]             win_src
);
   logic [POS_W-1:0] pos  [NUM_GROUPS];
   logic [SRC_W-1:0] gsrc [NUM_GROUPS];
   logic [POS_W-1:0] best;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pos
      localparam int GBASE = g * GROUP_SIZE;
      localparam int SBASE = NSRC + (g / 2) * 2 * GROUP_SIZE + (g % 2);
      place_e            mode;
      logic [LANE_W-1:0] s;

      assign mode    = place_e'(place[g]);
      assign s       = slot[g*LANE_W +: LANE_W];
      assign pos[g]  = (mode == PLACE_SPREAD) ? POS_W'(SBASE) + POS_W'({s, 1'b0})
                                              : POS_W'(GBASE) + POS_W'(s);
      assign gsrc[g] = SRC_W'(GBASE) + SRC_W'(lane[g*LANE_W +: LANE_W]);
   end

   always_comb begin
      win_v   = 1'b0;
      win_src = '0;
      best    = '1;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (hit[g] && (!win_v || pos[g] < best)) begin
            win_v   = 1'b1;
            best    = pos[g];
            win_src = gsrc[g];
         end
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl import irqc_pkg::*; #(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_SIZE = 8,
   parameter int NUM_MIXED  = 2,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   localparam int NSRC      = NUM_GROUPS * GROUP_SIZE,
   localparam int HALF      = GROUP_SIZE / 2,
   localparam int NUM_EXT   = NUM_MIXED * HALF,
   localparam int NUM_INT   = NSRC - NUM_EXT,
   localparam int LANE_W    = $clog2(GROUP_SIZE),
   localparam int SRC_W     = $clog2(NSRC),
   localparam int ORD_W     = GROUP_SIZE * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_INT-1:0] int_irq,
   input  logic [NUM_EXT-1:0] ext_irq,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NSRC-1:0]    pend_o,
   output logic               irq_out,
   output logic [VEC_W-1:0]   vec_out
);
   // elaboration-time parameter checks
   if (GROUP_SIZE < 2 || (GROUP_SIZE & (GROUP_SIZE - 1)) != 0) begin : g_bad_gs
      $error("GROUP_SIZE must be a power of two, at least 2");
   end
   if (NUM_MIXED < 1 || NUM_MIXED > NUM_GROUPS) begin : g_bad_mix
      $error("NUM_MIXED must lie in 1..NUM_GROUPS");
   end
   if (NSRC > DATA_W || ORD_W > DATA_W || DATA_W <= HP_EN_BIT) begin : g_bad_dw
      $error("DATA_W too narrow for the register layout");
   end
   if (NSRC + 1 > (1 << VEC_W) - 1 || SRC_W > HP_EN_BIT) begin : g_bad_vec
      $error("too many sources for the vector code");
   end
   if (ADDR_ORDER0 + NUM_GROUPS > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W cannot reach every order register");
   end

   function automatic logic [ORD_W-1:0] ident_order();
      logic [ORD_W-1:0] w;
      w = '0;
      for (int s = 0; s < GROUP_SIZE; s++) w[s*LANE_W +: LANE_W] = LANE_W'(s);
      return w;
   endfunction

   logic [NSRC-1:0]              src, pend_q, mask_q, act;
   logic [NUM_GROUPS-1:0]        place_q, g_hit;
   logic                         hp_en_q, hp_hit, arb_v, sel_v;
   logic [SRC_W-1:0]             hp_src_q, arb_src, sel_src;
   logic [ORD_W-1:0]             order_q [NUM_GROUPS];
   logic [NUM_GROUPS*LANE_W-1:0] g_slot, g_lane;

   irqc_src_map #(
      .NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE), .NUM_MIXED(NUM_MIXED)
   ) u_map (
      .int_irq(int_irq), .ext_irq(ext_irq), .src(src)
   );

   irqc_pend_bank #(
      .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_pend (
      .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pend_q(pend_q), .mask_q(mask_q)
   );

   // configuration: placement, override and slot orders
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         place_q  <= '0;
         hp_en_q  <= 1'b0;
         hp_src_q <= '0;
         for (int g = 0; g < NUM_GROUPS; g++) order_q[g] <= ident_order();
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADDR_PLACE))
            place_q <= wr_data[NUM_GROUPS-1:0];
         if (wr_addr == ADDR_W'(ADDR_TOP)) begin
            hp_src_q <= wr_data[SRC_W-1:0];
            hp_en_q  <= wr_data[HP_EN_BIT];
         end
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (wr_addr == ADDR_W'(ADDR_ORDER0 + g))
               order_q[g] <= wr_data[ORD_W-1:0];
         end
      end
   end

   assign act = pend_q & mask_q;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rank
      irqc_group_rank #(.GROUP_SIZE(GROUP_SIZE)) u_rank (
         .req  (act[g*GROUP_SIZE +: GROUP_SIZE]),
         .order(order_q[g]),
         .hit  (g_hit[g]),
         .slot (g_slot[g*LANE_W +: LANE_W]),
         .lane (g_lane[g*LANE_W +: LANE_W])
      );
   end

   irqc_table_arb #(
      .NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)
   ) u_arb (
      .hit(g_hit), .slot(g_slot), .lane(g_lane), .place(place_q),
      .win_v(arb_v), .win_src(arb_src)
   );

   assign hp_hit  = hp_en_q & act[hp_src_q];
   assign sel_v   = hp_hit | arb_v;
   assign sel_src = hp_hit ? hp_src_q : arb_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out <= 1'b0;
         vec_out <= '0;
      end else begin
         irq_out <= sel_v;
         vec_out <= sel_v ? VEC_W'(sel_src) + VEC_W'(1) : '0;
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk import irqc_pkg::*; #(
   parameter int NSRC   = 32,
   parameter int SRC_W  = 5,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [NSRC-1:0]   pend_q,
   input logic [NSRC-1:0]   mask_q,
   input logic              hp_en_q,
   input logic [SRC_W-1:0]  hp_src_q,
   input logic              irq_out,
   input logic [VEC_W-1:0]  vec_out
);
   logic [NSRC-1:0] act_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_d <= '0;
      else        act_d <= pend_q & mask_q;
   end

   assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> vec_out == '0);

   assert_none_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act_d == '0 |-> !irq_out);

   assert_vec_is_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (vec_out != '0 && act_d[SRC_W'(vec_out - VEC_W'(1))]));

   assert_clear_by_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend_q) & ~pend_q)) |-> ($past(wr_en) && $past(wr_addr) == ADDR_W'(ADDR_PEND)));

   assert_override_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_en_q && pend_q[hp_src_q] && mask_q[hp_src_q])
      |=> vec_out == VEC_W'($past(hp_src_q)) + VEC_W'(1));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NSRC(NSRC), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .pend_q(pend_q), .mask_q(mask_q), .hp_en_q(hp_en_q), .hp_src_q(hp_src_q),
   .irq_out(irq_out), .vec_out(vec_out)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
   localparam int NG = 4;
   localparam int GS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] int_irq = '0;
   logic [7:0]  ext_irq = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] pend_o;
   logic        irq_out;
   logic [6:0]  vec_out;

   always #10 clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .int_irq(int_irq), .ext_irq(ext_irq),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pend_o(pend_o), .irq_out(irq_out), .vec_out(vec_out)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;
   string cur_req = "R11";

   // behavioural reference state
   logic [31:0] m_pend, m_mask;
   logic [3:0]  m_place;
   logic        m_hp_en;
   int          m_hp_src;
   int          m_ord [NG][GS];
   int          e_vec;
   logic        e_irq;

   function automatic logic [31:0] lines_to_src(logic [23:0] ii, logic [7:0] ee);
      logic [31:0] v;
      for (int n = 0; n < 32; n++) begin
         int g;
         int l;
         g = n / 8;
         l = n % 8;
         if (g < 2)      v[n] = ii[n];
         else if (l < 4) v[n] = ii[16 + (g-2)*4 + l];
         else            v[n] = ee[(g-2)*4 + l - 4];
      end
      return v;
   endfunction

   function automatic int ref_winner();
      int          bp;
      int          bs;
      logic [31:0] act;
      bp  = 1000;
      bs  = -1;
      act = m_pend & m_mask;
      if (m_hp_en && act[m_hp_src]) return m_hp_src;
      for (int n = 0; n < 32; n++) begin
         if (act[n]) begin
            int g;
            int l;
            int r;
            int p;
            g = n / 8;
            l = n % 8;
            r = -1;
            for (int s = GS - 1; s >= 0; s--) if (m_ord[g][s] == l) r = s;
            if (r >= 0) begin
               p = m_place[g] ? 32 + (g/2)*16 + (g%2) + 2*r : g*8 + r;
               if (p < bp) begin
                  bp = p;
                  bs = n;
               end
            end
         end
      end
      return bs;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = '0; m_mask = '0; m_place = '0; m_hp_en = 1'b0; m_hp_src = 0;
         for (int g = 0; g < NG; g++) for (int s = 0; s < GS; s++) m_ord[g][s] = s;
         e_vec = 0; e_irq = 1'b0;
      end else begin
         int          w;
         logic [31:0] clr;
         w     = ref_winner();
         e_irq = (w >= 0);
         e_vec = (w >= 0) ? w + 1 : 0;
         clr   = (wr_en && wr_addr == 4'd0) ? wr_data : '0;
         m_pend = (m_pend & ~clr) | lines_to_src(int_irq, ext_irq);
         if (wr_en) begin
            case (wr_addr)
               4'd1: m_mask = wr_data;
               4'd2: m_place = wr_data[3:0];
               4'd3: begin m_hp_src = int'(wr_data[4:0]); m_hp_en = wr_data[8]; end
               4'd4, 4'd5, 4'd6, 4'd7:
                  for (int s = 0; s < GS; s++) m_ord[wr_addr-4][s] = int'(wr_data[3*s +: 3]);
               default: ;
            endcase
         end
      end
   end

   task automatic check(string rq, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "model pending", pend_o, m_pend);
         check(cur_req, "model vector", vec_out, e_vec);
         check(cur_req, "model request", irq_out, e_irq);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #3_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog: got timeout expected completion");
      finish_run();
   end

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic wr(int a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_line(int n, logic val);
      int g;
      int l;
      g = n / 8;
      l = n % 8;
      if (g < 2)      int_irq[n] = val;
      else if (l < 4) int_irq[16 + (g-2)*4 + l] = val;
      else            ext_irq[(g-2)*4 + l - 4] = val;
   endtask

   task automatic expect_vec(string rq, int v);
      check(rq, "vector", vec_out, v);
      check(rq, "request", irq_out, v != 0);
   endtask

   function automatic logic [31:0] ord_word(int rot);
      logic [31:0] w;
      w = '0;
      for (int s = 0; s < GS; s++) w[3*s +: 3] = 3'((s + rot) % GS);
      return w;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 / R4: reset state
      cur_req = "R11";
      expect_vec("R11", 0);
      check("R11", "pending after reset", pend_o, 0);

      // R1 / R5: disabled source still latches, is not reported
      cur_req = "R1";
      set_line(5, 1'b1); @(negedge clk); set_line(5, 1'b0); settle();
      check("R1", "pending bit 5", pend_o, 32'h20);
      expect_vec("R5", 0);

      // R3: enabling it reports source 5 as vector 6
      cur_req = "R3";
      wr(1, 32'hFFFF_FFFF); settle();
      expect_vec("R3", 6);

      // R2: acknowledge clears, held line survives acknowledge
      cur_req = "R2";
      wr(0, 32'h20); settle();
      check("R2", "pending after ack", pend_o, 0);
      expect_vec("R4", 0);
      set_line(9, 1'b1); @(negedge clk);
      wr(0, 32'h200); settle();
      check("R2", "held line keeps bit", pend_o[9], 1);
      set_line(9, 1'b0);
      wr(0, 32'hFFFF_FFFF); settle();
      expect_vec("R2", 0);

      // R6: rotation of group 0 order
      cur_req = "R6";
      for (int l = 0; l < 8; l++) set_line(l, 1'b1);
      @(negedge clk);
      for (int l = 0; l < 8; l++) set_line(l, 1'b0);
      settle();
      expect_vec("R6", 1);
      for (int r = 1; r < 8; r++) begin
         wr(4, ord_word(r)); settle();
         expect_vec("R6", r + 1);
      end
      wr(4, ord_word(0));
      wr(0, 32'hFFFF_FFFF); settle();

      // R7: duplicate lanes and an unnamed lane
      cur_req = "R7";
      set_line(1, 1'b1); set_line(2, 1'b1); set_line(5, 1'b1); @(negedge clk);
      set_line(1, 1'b0); set_line(2, 1'b0); set_line(5, 1'b0);
      wr(4, 32'h00B6_DB6D & 32'h00FF_FFFF | 32'h0); settle();
      // slot fields 0..6 = lane 2 (b010), slot 7 = lane 5 (b101)
      wr(4, {8'h0, 3'd5, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2}); settle();
      expect_vec("R7", 3);
      wr(0, 32'h4); settle();
      expect_vec("R7", 6);
      wr(0, 32'h20); settle();
      expect_vec("R7", 0);
      check("R7", "unnamed lane still pending", pend_o, 32'h2);
      wr(4, ord_word(0)); settle();
      expect_vec("R7", 2);
      wr(0, 32'hFFFF_FFFF); settle();

      // R8: grouped versus spread placement
      cur_req = "R8";
      set_line(11, 1'b1); set_line(24, 1'b1); @(negedge clk);
      set_line(11, 1'b0); set_line(24, 1'b0); settle();
      expect_vec("R8", 12);
      wr(2, 32'h2); settle();
      expect_vec("R8", 25);
      wr(2, 32'hA); settle();
      expect_vec("R8", 12);
      set_line(1, 1'b1); set_line(8, 1'b1); @(negedge clk);
      set_line(1, 1'b0); set_line(8, 1'b0);
      wr(2, 32'hB); settle();
      expect_vec("R8", 9);

      // R9: override
      cur_req = "R9";
      wr(2, 32'h0); settle();
      expect_vec("R9", 2);
      wr(3, 32'h118); settle();
      expect_vec("R9", 25);
      wr(3, 32'h018); settle();
      expect_vec("R9", 2);
      wr(3, 32'h118);
      wr(1, ~(32'h1 << 24)); settle();
      expect_vec("R9", 2);
      wr(1, 32'hFFFF_FFFF);
      wr(3, 32'h0);
      wr(0, 32'hFFFF_FFFF); settle();
      expect_vec("R9", 0);

      // R10: line-to-source mapping in mixed groups
      cur_req = "R10";
      ext_irq[0] = 1'b1; @(negedge clk); ext_irq[0] = 1'b0; settle();
      check("R10", "ext 0 pending", pend_o, 32'h1 << 20);
      expect_vec("R10", 21);
      wr(0, 32'hFFFF_FFFF);
      int_irq[21] = 1'b1; @(negedge clk); int_irq[21] = 1'b0; settle();
      check("R10", "int 21 pending", pend_o, 32'h1 << 25);
      expect_vec("R10", 26);
      wr(0, 32'hFFFF_FFFF);
      ext_irq[7] = 1'b1; @(negedge clk); ext_irq[7] = 1'b0; settle();
      check("R10", "ext 7 pending", pend_o, 32'h1 << 31);
      expect_vec("R10", 32);
      wr(0, 32'hFFFF_FFFF); settle();

      // random traffic against the reference (R3)
      cur_req = "R3";
      for (int i = 0; i < 400; i++) begin
         int op;
         int_irq = 24'($urandom & $urandom & $urandom);
         ext_irq = 8'($urandom & $urandom & $urandom);
         op = int'($urandom % 12);
         wr_en = 1'b1;
         case (op)
            0, 1: begin wr_addr = 4'd0; wr_data = $urandom; end
            2:    begin wr_addr = 4'd1; wr_data = $urandom | $urandom; end
            3:    begin wr_addr = 4'(4 + $urandom % 4); wr_data = $urandom; end
            4:    begin wr_addr = 4'd2; wr_data = $urandom; end
            5:    begin wr_addr = 4'd3; wr_data = $urandom & 32'h11F; end
            default: begin wr_en = 1'b0; wr_addr = 4'd0; wr_data = '0; end
         endcase
         @(negedge clk);
      end
      wr_en = 1'b0; int_irq = '0; ext_irq = '0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule